// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block is a serial digital audio port for a sound core. From a single system clock it derives a master clock for an oversampling converter, a bit clock and a left/right word select. It then shifts out two stereo output pairs on two parallel data lines and shifts in one stereo pair from a single input line. One frame holds 64 bit-clock periods: 32 for the left channel and 32 for the right. The master clock runs at 256 times the frame rate, so it gives four master-clock periods per bit clock.

Two framings are available. The first is I2S, with a data word of 16, 18 or 20 bits. The second is right-justified, which carries 16 bits only. On the core side, words are 20 bits wide and aligned to the most significant bit. The port latches the output words and the format selection on the last system-clock edge of each frame. On that same edge it publishes the input words received during the frame just ended. A one-cycle strobe in the first cycle of the new frame tells the core to supply the next output words.

Top module: `serial_audio_port`

## Requirements
- R1: With MCLK_HALF = 1, mclk has a period of 2 clk cycles and bclk has a period of 8 clk cycles, giving 4 mclk periods per bclk period. bclk is low for the first half of each bit period. There are exactly 64 bclk rising edges between consecutive frame strobes, and mclk is low in every cycle in which bclk has just fallen.
- R2: While rst_n is low, and before the first clk edge after its release, the outputs are: bclk=1, mclk=1, ws=0, sdout=0, frame_strobe=0, rx_left=0 and rx_right=0. The first frame starts on the first clk edge after release.
- R3: In I2S mode (fmt_rj=0), bit slots 0..31 belong to the left channel and slots 32..63 to the right channel. ws is 0 during slots 63 and 0..30, and 1 during slots 31..62. It therefore changes one slot before each channel's MSB.
- R4: In I2S mode, fmt_width selects the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 16. A channel's word is sent MSB first from the channel's first slot, using the top W bits of its 20-bit register. The remaining slots of the half-frame carry 0.
- R5: In right-justified mode (fmt_rj=1), ws is 1 during slots 0..31 (left) and 0 during slots 32..63. Each half-frame is 16 zeros followed by the top 16 bits of the word, MSB first, with the LSB in the last slot. fmt_width has no effect in this mode.
- R6: ws and sdout change only when bclk falls, so both are unchanged at every rising edge of bclk.
- R7: sdin is sampled at each rising edge of bclk, in the slots that carry data for the current format. Bits in the other slots are ignored. The received words appear MSB-aligned in rx_left and rx_right, with all bits not received set to 0.
- R8: frame_strobe is high for exactly one clk cycle per frame, in the first cycle of the frame. rx_left and rx_right change only in that cycle. tx_samples, fmt_rj and fmt_width are sampled only on the edge that starts a frame, so changing them during a frame does not affect that frame.
- R9: Lane n of sdout carries the pair at tx_samples[40n+19:40n] (left) and tx_samples[40n+39:40n+20] (right). All lanes use the same slots and framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_rj | input | 1 | 1 selects right-justified framing, 0 selects I2S |
| fmt_width | input | 2 | I2S word length code (0:16, 1:18, 2:20, 3:16) |
| tx_samples | input | NUM_OUT*40 | Output words, one left/right pair of 20 bits per lane |
| sdin | input | 1 | Serial input data |
| mclk | output | 1 | Master clock, 256 times the frame rate |
| bclk | output | 1 | Bit clock, 64 times the frame rate |
| ws | output | 1 | Left/right word select |
| sdout | output | NUM_OUT | Serial output data, one line per stereo pair |
| rx_left | output | 20 | Last received left word, MSB-aligned |
| rx_right | output | 20 | Last received right word, MSB-aligned |
| frame_strobe | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The bench steps through every word-length code in I2S mode and two codes in right-justified mode. For each frame it changes the output words and the format immediately after the strobe, so a port that sampled its inputs continuously would send mixed words and fail R8. It drives ones into the sdin slots that carry no data. A deserializer that captured outside the data window would then show stray set bits in the low-order positions. Code 3 and right-justified mode with a non-zero width code catch a decoder that lets the width leak into the wrong mode. Comparing ws and sdout against the model on every cycle exposes a word select that is off by one slot, which would move the MSB away from the slot after the ws change.

// File: rtl/audio_port_pkg.sv
`timescale 1ns/1ps
package audio_port_pkg;

    localparam int SLOTS     = 64;
    localparam int HALF      = SLOTS / 2;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int SAMPLE_W  = 20;
    localparam int RJ_BITS   = 16;
    localparam int RJ_START  = HALF - RJ_BITS;

    typedef enum logic [1:0] {
        WID_16  = 2'd0,
        WID_18  = 2'd1,
        WID_20  = 2'd2,
        WID_RSV = 2'd3
    } width_e;

    typedef struct packed {
        logic   rj;
        width_e wid;
    } fmt_t;

    localparam fmt_t FMT_RESET = '{rj: 1'b0, wid: WID_16};

    function automatic int data_bits(input width_e w);
        case (w)
            WID_18:  return 18;
            WID_20:  return 20;
            default: return 16;
        endcase
    endfunction

    // position of a slot inside its half-frame
    function automatic int half_pos(input logic [SLOT_W-1:0] s);
        return int'(s[SLOT_W-2:0]);
    endfunction

    function automatic logic slot_carries(input fmt_t f, input logic [SLOT_W-1:0] s);
        if (f.rj)
            return half_pos(s) >= RJ_START;
        return half_pos(s) < data_bits(f.wid);
    endfunction

    // register bit addressed by a data-carrying slot (MSB-aligned words)
    function automatic int slot_index(input fmt_t f, input logic [SLOT_W-1:0] s);
        if (f.rj)
            return SAMPLE_W - 1 - (half_pos(s) - RJ_START);
        return SAMPLE_W - 1 - half_pos(s);
    endfunction

    function automatic logic ws_level(input fmt_t f, input logic [SLOT_W-1:0] s);
        if (f.rj)
            return ~s[SLOT_W-1];
        return !((s == SLOT_W'(SLOTS - 1)) || (s < SLOT_W'(HALF - 1)));
    endfunction

    function automatic logic tx_bit(input fmt_t f, input logic [SLOT_W-1:0] s,
                                    input logic [SAMPLE_W-1:0] l,
                                    input logic [SAMPLE_W-1:0] r);
        if (!slot_carries(f, s))
            return 1'b0;
        if (s[SLOT_W-1])
            return r[slot_index(f, s)];
        return l[slot_index(f, s)];
    endfunction

endpackage

// File: rtl/aud_clkgen.sv
`timescale 1ns/1ps
module aud_clkgen
    import audio_port_pkg::*;
#(
    parameter int MCLK_HALF = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mclk,
    output logic              bclk,
    output logic              frame_edge,
    output logic              capture,
    output logic [SLOT_W-1:0] slot_cur,
    output logic [SLOT_W-1:0] slot_nxt
);

    localparam int BCLK_DIV  = 8 * MCLK_HALF;
    localparam int BCLK_HALF = BCLK_DIV / 2;
    localparam int TICK_W    = $clog2(BCLK_DIV);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(BCLK_DIV - 1);
    localparam logic [TICK_W-1:0] TICK_RISE = TICK_W'(BCLK_HALF);
    localparam logic [TICK_W-1:0] TICK_PRE  = TICK_W'(BCLK_HALF - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic MCLK_RST = (((BCLK_DIV - 1) / MCLK_HALF) % 2) != 0;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [SLOT_W-1:0] slot;
        logic              mclk;
        logic              bclk;
    } cg_t;

    cg_t cg_q, cg_d;

    function automatic logic mclk_phase(input logic [TICK_W-1:0] t);
        return ((int'(t) / MCLK_HALF) % 2) != 0;
    endfunction

    always_comb begin
        cg_d = cg_q;
        if (cg_q.tick == TICK_LAST) begin
            cg_d.tick = '0;
            cg_d.slot = (cg_q.slot == SLOT_LAST) ? '0 : cg_q.slot + 1'b1;
        end else begin
            cg_d.tick = cg_q.tick + 1'b1;
        end
        cg_d.mclk = mclk_phase(cg_d.tick);
        cg_d.bclk = cg_d.tick >= TICK_RISE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cg_q <= '{tick: TICK_LAST, slot: SLOT_LAST, mclk: MCLK_RST, bclk: 1'b1};
        else
            cg_q <= cg_d;
    end

    assign mclk       = cg_q.mclk;
    assign bclk       = cg_q.bclk;
    assign frame_edge = (cg_q.tick == TICK_LAST) && (cg_q.slot == SLOT_LAST);
    assign capture    = cg_q.tick == TICK_PRE;
    assign slot_cur   = cg_q.slot;
    assign slot_nxt   = cg_d.slot;

endmodule

// File: rtl/aud_tx_lane.sv
`timescale 1ns/1ps
module aud_tx_lane
    import audio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_edge,
    input  logic [SLOT_W-1:0]   slot_nxt,
    input  fmt_t                fmt_nxt,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                sd
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                sd;
    } lane_t;

    lane_t ln_q, ln_d;

    always_comb begin
        ln_d = ln_q;
        if (frame_edge) begin
            ln_d.left  = left_in;
            ln_d.right = right_in;
        end
        ln_d.sd = tx_bit(fmt_nxt, slot_nxt, ln_d.left, ln_d.right);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ln_q <= '0;
        else
            ln_q <= ln_d;
    end

    assign sd = ln_q.sd;

endmodule

// File: rtl/aud_rx.sv
`timescale 1ns/1ps
module aud_rx
    import audio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                frame_edge,
    input  logic [SLOT_W-1:0]   slot_cur,
    input  fmt_t                fmt_cur,
    input  logic                sdin,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] acc_l;
        logic [SAMPLE_W-1:0] acc_r;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
    } rx_t;

    rx_t rx_q, rx_d;

    always_comb begin
        rx_d = rx_q;
        if (capture && slot_carries(fmt_cur, slot_cur)) begin
            if (slot_cur[SLOT_W-1])
                rx_d.acc_r[slot_index(fmt_cur, slot_cur)] = sdin;
            else
                rx_d.acc_l[slot_index(fmt_cur, slot_cur)] = sdin;
        end
        if (frame_edge) begin
            rx_d.out_l = rx_q.acc_l;
            rx_d.out_r = rx_q.acc_r;
            rx_d.acc_l = '0;
            rx_d.acc_r = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= '0;
        else
            rx_q <= rx_d;
    end

    assign rx_left  = rx_q.out_l;
    assign rx_right = rx_q.out_r;

endmodule

// File: rtl/serial_audio_port.sv
`timescale 1ns/1ps
module serial_audio_port
    import audio_port_pkg::*;
#(
    parameter int MCLK_HALF = 1,
    parameter int NUM_OUT   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fmt_rj,
    input  logic [1:0]                    fmt_width,
    input  logic [NUM_OUT*2*SAMPLE_W-1:0] tx_samples,
    input  logic                          sdin,
    output logic                          mclk,
    output logic                          bclk,
    output logic                          ws,
    output logic [NUM_OUT-1:0]            sdout,
    output logic [SAMPLE_W-1:0]           rx_left,
    output logic [SAMPLE_W-1:0]           rx_right,
    output logic                          frame_strobe
);

    localparam int PAIR_W = 2 * SAMPLE_W;

    typedef struct packed {
        fmt_t fmt;
        logic ws;
        logic strobe;
    } top_t;

    top_t tp_q, tp_d;

    logic              frame_edge;
    logic              capture;
    logic [SLOT_W-1:0] slot_cur;
    logic [SLOT_W-1:0] slot_nxt;

    aud_clkgen #(
        .MCLK_HALF (MCLK_HALF)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk       (mclk),
        .bclk       (bclk),
        .frame_edge (frame_edge),
        .capture    (capture),
        .slot_cur   (slot_cur),
        .slot_nxt   (slot_nxt)
    );

    always_comb begin
        tp_d = tp_q;
        if (frame_edge) begin
            tp_d.fmt.rj  = fmt_rj;
            tp_d.fmt.wid = width_e'(fmt_width);
        end
        tp_d.ws     = ws_level(tp_d.fmt, slot_nxt);
        tp_d.strobe = frame_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tp_q <= '{fmt: FMT_RESET, ws: 1'b0, strobe: 1'b0};
        else
            tp_q <= tp_d;
    end

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
        aud_tx_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_edge (frame_edge),
            .slot_nxt   (slot_nxt),
            .fmt_nxt    (tp_d.fmt),
            .left_in    (tx_samples[n*PAIR_W +: SAMPLE_W]),
            .right_in   (tx_samples[n*PAIR_W + SAMPLE_W +: SAMPLE_W]),
            .sd         (sdout[n])
        );
    end

    aud_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .frame_edge (frame_edge),
        .slot_cur   (slot_cur),
        .fmt_cur    (tp_q.fmt),
        .sdin       (sdin),
        .rx_left    (rx_left),
        .rx_right   (rx_right)
    );

    assign ws           = tp_q.ws;
    assign frame_strobe = tp_q.strobe;

endmodule

// File: rtl/serial_audio_port_chk.sv
`timescale 1ns/1ps
module serial_audio_port_chk
    import audio_port_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mclk,
    input logic                bclk,
    input logic                ws,
    input logic [NUM_OUT-1:0]  sdout,
    input logic [SAMPLE_W-1:0] rx_left,
    input logic [SAMPLE_W-1:0] rx_right,
    input logic                frame_strobe
);

    localparam int CNT_W = $clog2(SLOTS) + 2;

    logic [CNT_W-1:0] rise_cnt_q;
    logic             seen_q;
    logic             bclk_prev_q;
    logic             bclk_rise;

    assign bclk_rise = bclk && !bclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q  <= '0;
            seen_q      <= 1'b0;
            bclk_prev_q <= 1'b1;
        end else begin
            bclk_prev_q <= bclk;
            if (frame_strobe) begin
                rise_cnt_q <= '0;
                seen_q     <= 1'b1;
            end else if (bclk_rise) begin
                rise_cnt_q <= rise_cnt_q + 1'b1;
            end
        end
    end

    // R1
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && seen_q) |-> (rise_cnt_q == CNT_W'(SLOTS)));

    // R1
    mclk_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |-> !mclk);

    // R6
    ws_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> $stable(ws));

    // R6
    sdout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> $stable(sdout));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    // R8
    strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> $fell(bclk));

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> ($stable(rx_left) && $stable(rx_right)));

endmodule

bind serial_audio_port serial_audio_port_chk #(
    .NUM_OUT (NUM_OUT)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mclk         (mclk),
    .bclk         (bclk),
    .ws           (ws),
    .sdout        (sdout),
    .rx_left      (rx_left),
    .rx_right     (rx_right),
    .frame_strobe (frame_strobe)
);

// File: tb/test_serial_audio_port.sv
`timescale 1ns/1ps
module test_serial_audio_port;

    localparam int NOUT = 2;
    localparam int SWD  = 20;
    localparam int DIV  = 8;            // clk cycles per bit clock
    localparam int FR   = 64 * DIV;     // clk cycles per frame

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   fmt_rj = 1'b0;
    logic [1:0]             fmt_width = 2'd0;
    logic [NOUT*2*SWD-1:0]  tx_samples = '0;
    logic                   sdin = 1'b0;
    logic                   mclk, bclk, ws, frame_strobe;
    logic [NOUT-1:0]        sdout;
    logic [SWD-1:0]         rx_left, rx_right;

    serial_audio_port #(.MCLK_HALF(1), .NUM_OUT(NOUT)) i_serial_audio_port (
        .clk(clk), .rst_n(rst_n), .fmt_rj(fmt_rj), .fmt_width(fmt_width),
        .tx_samples(tx_samples), .sdin(sdin), .mclk(mclk), .bclk(bclk), .ws(ws),
        .sdout(sdout), .rx_left(rx_left), .rx_right(rx_right),
        .frame_strobe(frame_strobe)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int k = 0;
    bit done = 0;

    // reference model state
    logic [NOUT*2*SWD-1:0] m_tx = '0;
    logic       m_rj = 1'b0;
    int         m_w = 0;
    logic [SWD-1:0] m_pl = '0, m_pr = '0;   // sdin pattern for current frame
    logic [SWD-1:0] p_pl = '0, p_pr = '0;   // pattern for the next frame
    logic [SWD-1:0] e_rl = '0, e_rr = '0;   // expected rx words
    logic prev_ws = 1'b0;
    logic [NOUT-1:0] prev_sd = '0;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, k, act, exp);
        end
    endtask

    function automatic int wlen(input int code);
        if (code == 1) return 18;
        if (code == 2) return 20;
        return 16;
    endfunction

    function automatic bit carries(input logic rj, input int code, input int slot);
        int h = slot % 32;
        if (rj) return h >= 16;
        return h < wlen(code);
    endfunction

    function automatic logic word_bit(input logic rj, input int code, input int slot,
                                      input logic [SWD-1:0] w);
        int h = slot % 32;
        if (!carries(rj, code, slot)) return 1'b0;
        if (rj) return w[SWD-1-(h-16)];
        return w[SWD-1-h];
    endfunction

    function automatic logic [SWD-1:0] keep(input logic rj, input int code,
                                            input logic [SWD-1:0] w);
        int n = rj ? 16 : wlen(code);
        logic [SWD-1:0] m = '0;
        for (int i = 0; i < n; i++) m[SWD-1-i] = 1'b1;
        return w & m;
    endfunction

    function automatic logic exp_ws(input logic rj, input int slot);
        if (rj) return slot < 32;
        return (slot >= 31) && (slot <= 62);
    endfunction

    task automatic cycle();
        int pos, tick, slot;
        string dreq;
        @(posedge clk);
        @(negedge clk);
        k++;
        if (k % FR == 1) begin
            e_rl = keep(m_rj, m_w, m_pl);
            e_rr = keep(m_rj, m_w, m_pr);
            m_tx = tx_samples;
            m_rj = fmt_rj;
            m_w  = int'(fmt_width);
            m_pl = p_pl;
            m_pr = p_pr;
        end
        pos  = (FR - 1 + k) % FR;
        tick = pos % DIV;
        slot = pos / DIV;
        chk("R1", "bclk", 32'(bclk), 32'(tick >= DIV/2));
        chk("R1", "mclk", 32'(mclk), 32'(tick % 2));
        chk(m_rj ? "R5" : "R3", "ws", 32'(ws), 32'(exp_ws(m_rj, slot)));
        for (int n = 0; n < NOUT; n++) begin
            logic [SWD-1:0] w;
            w = (slot < 32) ? m_tx[n*2*SWD +: SWD] : m_tx[n*2*SWD + SWD +: SWD];
            dreq = (n > 0) ? "R9" : (m_rj ? "R5" : "R4");
            chk(dreq, $sformatf("sdout[%0d] slot %0d", n, slot), 32'(sdout[n]),
                32'(word_bit(m_rj, m_w, slot, w)));
        end
        chk("R8", "frame_strobe", 32'(frame_strobe), 32'(k % FR == 1));
        chk("R7", "rx_left", 32'(rx_left), 32'(e_rl));
        chk("R7", "rx_right", 32'(rx_right), 32'(e_rr));
        if (tick == DIV/2) begin
            chk("R6", "ws at bclk rise", 32'(ws), 32'(prev_ws));
            chk("R6", "sdout at bclk rise", 32'(sdout), 32'(prev_sd));
        end
        prev_ws = ws;
        prev_sd = sdout;
        // sdin for this slot: pattern bit in data slots, one elsewhere (must be ignored)
        if (carries(m_rj, m_w, slot))
            sdin = (slot < 32) ? m_pl[SWD-1-((slot%32) - (m_rj ? 16 : 0))]
                               : m_pr[SWD-1-((slot%32) - (m_rj ? 16 : 0))];
        else
            sdin = 1'b1;
    endtask

    task automatic set_frame(input int f);
        case (f % 6)
            0: begin fmt_rj = 1'b0; fmt_width = 2'd0; end
            1: begin fmt_rj = 1'b0; fmt_width = 2'd1; end
            2: begin fmt_rj = 1'b0; fmt_width = 2'd2; end
            3: begin fmt_rj = 1'b0; fmt_width = 2'd3; end
            4: begin fmt_rj = 1'b1; fmt_width = 2'd0; end
            default: begin fmt_rj = 1'b1; fmt_width = 2'd2; end
        endcase
        if (f == 0) begin
            tx_samples = '1;
            p_pl = '1;
            p_pr = 20'h80001;
        end else begin
            tx_samples = {$urandom, $urandom, $urandom};
            p_pl = SWD'($urandom);
            p_pr = SWD'($urandom);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R2: reset values before any clock edge after release
        chk("R2", "bclk", 32'(bclk), 32'd1);
        chk("R2", "mclk", 32'(mclk), 32'd1);
        chk("R2", "ws", 32'(ws), 32'd0);
        chk("R2", "sdout", 32'(sdout), 32'd0);
        chk("R2", "frame_strobe", 32'(frame_strobe), 32'd0);
        chk("R2", "rx_left", 32'(rx_left), 32'd0);
        chk("R2", "rx_right", 32'(rx_right), 32'd0);
        set_frame(0);
        rst_n = 1'b1;
        chk("R2", "bclk after release", 32'(bclk), 32'd1);
        cycle();
        for (int f = 1; f < 15; f++) begin
            // inputs change mid-frame; they must only take effect at the next boundary (R8)
            set_frame(f);
            do cycle(); while (k % FR != 1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", k);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule